// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a simple word-addressed read/write bus and the byte-level halves of a serial port. Bytes arriving from a deserializer on a byte-valid input are held in a small circular receive queue until the host reads them. Each byte the host writes to the transmit word is passed on, one cycle later, as a single-cycle byte-valid pulse toward a serializer. The block treats transmission as immediate, so its transmit side is always reported empty.

The host sees four words: receive data, transmit data, status and control. The host can clear the receive queue through a control bit. One level interrupt line is asserted while a sticky pending flag is set and the host has enabled interrupts. The pending flag is raised by any accepted received byte and by any transmit write. Only reset clears it.

Bus reads are combinational from the word index. A receive-data read consumes its byte on the clock edge of the access.

Top module: `uart_rif`

## Requirements
- R1: The register word is selected by byte-address bits [3:2]: 0 receive data, 1 transmit data, 2 status, 3 control. Address bits [1:0] have no effect.
- R2: The receive queue holds DEPTH (default 8) bytes. Receive-data reads return bytes in arrival order, in bits [7:0] with the upper bits zero. Each read of a non-empty queue removes one byte at the clock edge.
- R3: A byte that arrives while the queue holds DEPTH bytes is dropped, and the stored bytes and their order are unchanged.
- R4: A receive-data read of an empty queue returns the slot at the current write position and leaves the queue empty.
- R5: The status word reads as follows: bit0 = queue non-empty, bit1 = queue holds DEPTH bytes, bit2 = 1 (transmit empty), bit3 = 0 (transmit full), bit4 = interrupt pending, bits 7:5 and 31:8 = 0.
- R6: A control write stores wdata[7:0], which reads back through the control word. If wdata bit1 is set, the write also empties the queue and returns the write position to slot 0. A byte arriving in the same cycle is dropped.
- R7: The pending flag is set at the edge that accepts a received byte or performs a transmit write. It stays set until reset.
- R8: irq_o is high exactly when the pending flag is set and control bit4 is set.
- R9: A transmit write drives tx_valid_o high for exactly the next cycle, with tx_data_o equal to wdata[7:0]. A transmit-data read returns that byte.
- R10: Writes to the status word and to the receive-data word change no state.
- R11: After reset the queue is empty, control, the transmit byte and the pending flag are zero, tx_valid_o and irq_o are low, and the status word reads 0x04.
- R12: When a receive-data read and an arriving byte fall in the same cycle, the read returns the oldest stored byte and the arriving byte is stored. The arriving byte is still dropped if the queue held DEPTH bytes before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (4) | Byte address; bits [3:2] select the word |
| bus_wdata_i | input | BUS_W (32) | Write data |
| bus_rdata_o | output | BUS_W (32) | Read data for the addressed word, combinational |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | One-cycle transmit byte strobe |
| tx_data_o | output | 8 | Last byte written for transmission |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a queue depth of 8, a 4-bit byte address and a 32-bit bus. With this shallow depth, a burst of ten arrivals reaches the full flag, the dropping of excess bytes and a complete wrap of the write position within a few dozen cycles. Queue clears and empty reads then land at non-zero write positions, which exposes any error in how the stale slot is selected. Same-cycle reads and arrivals are exercised both at partial fill and at full.

// File: rtl/uart_rif_pkg.sv
package uart_rif_pkg;
  typedef enum logic [1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_idx_e;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ST_RX_VLD  = 0;
  localparam int unsigned ST_RX_FULL = 1;
  localparam int unsigned ST_TX_EMPT = 2;
  localparam int unsigned ST_TX_FULL = 3;
  localparam int unsigned ST_PEND    = 4;
  localparam int unsigned CT_TX_RST  = 0;
  localparam int unsigned CT_RX_RST  = 1;
  localparam int unsigned CT_IE      = 4;
endpackage

// File: rtl/uart_rif_rx_fifo.sv
module uart_rif_rx_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              clr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              push_ok_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  rd_idx;
  logic              push_ok, pop_ok;

  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok   = push_i & ~full_o & ~clr_i;
  assign pop_ok    = pop_i & (cnt_q != '0) & ~clr_i;
  // depth is a power of two: subtraction wraps modulo DEPTH
  assign rd_idx    = wr_q - cnt_q[PTR_W-1:0];
  assign rd_data_o = mem_q[rd_idx];
  assign count_o   = cnt_q;
  assign push_ok_o = push_ok;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[i] <= '0;
      else if (push_ok && wr_q == PTR_W'(i))      mem_q[i] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  // R3
  drop_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> (full_o && $stable(wr_q)));
  // R4
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && pop_i && !push_i && !clr_i) |=> (cnt_q == '0));
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_rif_irq.sv
module uart_rif_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ie_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & ie_i;

  // R7
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> pend_q);
  // R7
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);
endmodule

// File: rtl/uart_rif.sv
module uart_rif #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BUS_W  = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              irq_o
);
  import uart_rif_pkg::*;

  reg_idx_e          word;
  logic              wr_en, rd_en, tx_wr, ctrl_wr, rx_clr, rx_pop;
  logic [BYTE_W-1:0] fifo_rd, ctrl_q, tx_q;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_full, push_ok, pend, tx_vld_q;
  logic [BYTE_W-1:0] stat;
  logic              unused_bits;

  assign word    = reg_idx_e'(bus_addr_i[3:2]);
  assign wr_en   = bus_sel_i & bus_we_i;
  assign rd_en   = bus_sel_i & ~bus_we_i;
  assign tx_wr   = wr_en & (word == REG_TXD);
  assign ctrl_wr = wr_en & (word == REG_CTRL);
  assign rx_clr  = ctrl_wr & bus_wdata_i[CT_RX_RST];
  assign rx_pop  = rd_en & (word == REG_RXD);
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[BUS_W-1:BYTE_W], ctrl_q[CT_TX_RST]};

  uart_rif_rx_fifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) i_rx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_valid_i),
    .push_data_i (rx_data_i),
    .pop_i       (rx_pop),
    .clr_i       (rx_clr),
    .rd_data_o   (fifo_rd),
    .count_o     (fifo_cnt),
    .full_o      (fifo_full),
    .push_ok_o   (push_ok)
  );

  uart_rif_irq i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (push_ok | tx_wr),
    .ie_i   (ctrl_q[CT_IE]),
    .pend_o (pend),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      tx_q     <= '0;
      tx_vld_q <= 1'b0;
    end else begin
      tx_vld_q <= tx_wr;
      if (tx_wr)   tx_q   <= bus_wdata_i[BYTE_W-1:0];
      if (ctrl_wr) ctrl_q <= bus_wdata_i[BYTE_W-1:0];
    end
  end

  always_comb begin
    stat             = '0;
    stat[ST_RX_VLD]  = (fifo_cnt != '0);
    stat[ST_RX_FULL] = fifo_full;
    stat[ST_TX_EMPT] = 1'b1;
    stat[ST_TX_FULL] = 1'b0;
    stat[ST_PEND]    = pend;
  end

  always_comb begin
    unique case (word)
      REG_RXD:  bus_rdata_o = BUS_W'(fifo_rd);
      REG_TXD:  bus_rdata_o = BUS_W'(tx_q);
      REG_STAT: bus_rdata_o = BUS_W'(stat);
      default:  bus_rdata_o = BUS_W'(ctrl_q);
    endcase
  end

  assign tx_valid_o = tx_vld_q;
  assign tx_data_o  = tx_q;

  // R9
  tx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr |=> (tx_valid_o && tx_data_o == $past(bus_wdata_i[7:0])));
  // R9
  tx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_wr |=> !tx_valid_o);
  // R6
  rx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr |=> (fifo_cnt == '0));
  // R8
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !bus_wdata_i[CT_IE]) |=> !irq_o);
  // R10
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && word == REG_STAT) |=> ($stable(ctrl_q) && $stable(tx_q)));
endmodule

// File: tb/test_uart_rif.sv
`timescale 1ns/1ps
module test_uart_rif;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel = 1'b0, we = 1'b0, rxv = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  rxd = '0;
  logic [31:0] rdata;
  logic        txv, irq;
  logic [7:0]  txd;

  always #10 clk = ~clk;

  uart_rif i_uart_rif (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_valid_i(rxv), .rx_data_i(rxd), .tx_valid_o(txv),
    .tx_data_o(txd), .irq_o(irq)
  );

  // reference model
  byte unsigned m_mem [8];
  int           m_wp, m_cnt;
  byte unsigned m_ctrl, m_tx;
  bit           m_txv, m_pend;
  int           n_chk = 0, n_bad = 0;
  string        cur_req = "R11";
  bit           done = 0;

  function automatic void m_reset();
    foreach (m_mem[i]) m_mem[i] = 0;
    m_wp = 0; m_cnt = 0; m_ctrl = 0; m_tx = 0; m_txv = 0; m_pend = 0;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a[3:2])
      2'd0: return {24'b0, m_mem[(m_wp - m_cnt + 8) % 8]};
      2'd1: return {24'b0, m_tx};
      2'd2: return {27'b0, m_pend, 1'b0, 1'b1, m_cnt == 8, m_cnt != 0};
      default: return {24'b0, m_ctrl};
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic w, logic [3:0] a, logic [31:0] d,
                     logic rv, logic [7:0] rb);
    bit clr, push, pop;
    @(negedge clk);
    sel = s; we = w; addr = a; wdata = d; rxv = rv; rxd = rb;
    #1;
    chk("rdata", rdata, m_read(a));
    chk("tx_valid", {31'b0, txv}, {31'b0, m_txv});
    chk("tx_data", {24'b0, txd}, {24'b0, m_tx});
    chk("irq", {31'b0, irq}, {31'b0, m_pend & m_ctrl[4]});
    @(posedge clk);
    clr  = s && w && a[3:2] == 2'd3 && d[1];
    pop  = s && !w && a[3:2] == 2'd0 && m_cnt != 0;
    push = rv && m_cnt < 8 && !clr;
    if (push) begin m_mem[m_wp] = rb; m_pend = 1; end
    m_txv = 0;
    if (s && w && a[3:2] == 2'd1) begin m_tx = d[7:0]; m_txv = 1; m_pend = 1; end
    if (s && w && a[3:2] == 2'd3) m_ctrl = d[7:0];
    if (clr) begin m_wp = 0; m_cnt = 0; end
    else begin
      m_wp  = (m_wp + (push ? 1 : 0)) % 8;
      m_cnt = m_cnt + (push ? 1 : 0) - (pop ? 1 : 0);
    end
  endtask

  task automatic idle(logic [3:0] a); cyc(0, 0, a, 0, 0, 0); endtask
  task automatic rd(logic [3:0] a); cyc(1, 0, a, 0, 0, 0); endtask
  task automatic wr(logic [3:0] a, logic [31:0] d); cyc(1, 1, a, d, 0, 0); endtask
  task automatic rx(logic [7:0] b); cyc(0, 0, 4'h8, 0, 1, b); endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; sel = 0; rxv = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1; m_reset();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_reset();
    do_reset();
    cur_req = "R11"; idle(4'h8); idle(4'h0); idle(4'hC); idle(4'h4);
    cur_req = "R5";  rd(4'h8);
    cur_req = "R9";  wr(4'h4, 32'hDEAD_BEA5); idle(4'h4); idle(4'h8);
    wr(4'h4, 32'h0000_0011); wr(4'h4, 32'h0000_0022); idle(4'h4);
    cur_req = "R8";  wr(4'hC, 32'h10); idle(4'h8); wr(4'hC, 32'h01); idle(4'h8);
    cur_req = "R7";  rd(4'h8); idle(4'h8);
    do_reset();
    cur_req = "R2";  rx(8'h31); rx(8'h32); rx(8'h33);
    rd(4'h0); rd(4'h1); rd(4'h2); idle(4'h8);
    cur_req = "R3";
    for (int i = 0; i < 10; i++) rx(8'h40 + 8'(i));
    rd(4'h8);
    cur_req = "R12"; cyc(1, 0, 4'h0, 0, 1, 8'h77); rd(4'h8);
    cyc(1, 0, 4'h0, 0, 1, 8'h78); rd(4'h8);
    cur_req = "R2";
    for (int i = 0; i < 8; i++) rd(4'h0);
    cur_req = "R4";  rd(4'h0); rd(4'h3); rd(4'h8);
    cur_req = "R6";  rx(8'h91); rx(8'h92); rx(8'h93);
    cyc(1, 1, 4'hC, 32'h12, 1, 8'h94); rd(4'hC); rd(4'h8); rd(4'h0); rd(4'h0);
    cur_req = "R10"; rx(8'h55); wr(4'h8, 32'hFFFF_FFFF); wr(4'h0, 32'hAA);
    rd(4'h8); rd(4'h4); rd(4'hC);
    cur_req = "R1";  rd(4'hB); rd(4'h6); rd(4'h9); rd(4'h1);
    cur_req = "R12";
    for (int i = 0; i < 6; i++) cyc(1, 0, 4'h0, 0, 1, 8'hC0 + 8'(i));
    rd(4'h8); rd(4'h0); rd(4'h0); idle(4'h8);
    cur_req = "R8";  wr(4'hC, 32'h00); idle(4'h8); wr(4'hC, 32'h10); idle(4'h8);
    finish_run();
  end
endmodule